// File: doc/BRIEF.md
# Extended-Length Serial Transmitter

This block is the transmit half of an asynchronous/synchronous serial port whose character length can be 5, 6, 7, 8, 9, 13, 14, 15 or 16 data bits. Characters longer than eight bits are loaded in two writes. The upper bits go first into an extension register. The low byte then goes into the main data register, and that low-byte write launches the character. Each character is framed with a low start bit, the data bits sent least significant bit first, an optional parity bit and one or two high stop bits.

Bit timing comes from outside the block. In asynchronous mode a one-cycle baud tick advances the line by one bit. In synchronous mode a rising edge on an external clock pin does the same, and the baud tick is ignored. While the transmitter is enabled it owns the serial pin. Otherwise the pin follows the ordinary port value.

Top module: `ext_uart_tx`

## Requirements
- R1: After reset the holding register is empty (`buf_empty` = 1), no frame is in progress, and with `tx_en` low `txd` follows `port_out`.
- R2: `cfg_len` gives the data length as a binary bit count. The values 5, 6, 7, 8, 9, 13, 14, 15 and 16 select that many bits. Any other value selects 8 bits.
- R3: A `low_wr` pulse latches `{ext register, low_data}` into the holding register, and that write alone starts a frame. An `ext_wr` pulse only updates the 8-bit extension register (data bits 15:8) and never starts a frame. A `low_wr` in the same cycle as an `ext_wr` uses the earlier extension value.
- R4: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits. The line moves on by one bit per bit strobe.
- R5: `cfg_parity` encodings are 2'b00 none, 2'b01 even (data plus parity has an even count of ones), 2'b10 odd, and 2'b11 none.
- R6: `cfg_stop2` = 1 sends two high stop bits. `cfg_stop2` = 0 sends one.
- R7: `buf_empty` goes low in the cycle after an accepted `low_wr`. It goes high again in the cycle the holding register moves into the shift register, which is also the cycle the start bit appears. A `low_wr` while `buf_empty` is low is ignored.
- R8: While enabled and with no frame in progress, `txd` is high.
- R9: When `cfg_sync` = 1, bits advance on rising edges of `xclk` and `baud_tick` has no effect. When `cfg_sync` = 0, bits advance on `baud_tick` pulses.
- R10: If `tx_en` falls during a frame, that frame completes unchanged and `txd` then returns to `port_out`. Writes while disabled are ignored.
- R11: For lengths of 8 or fewer, the extension register has no effect on the frame, and data bits at and above the length are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable, takes over the serial pin |
| cfg_len | input | 5 | Data bits per character (binary count) |
| cfg_parity | input | 2 | Parity select: none, even, odd |
| cfg_stop2 | input | 1 | Two stop bits when set |
| cfg_sync | input | 1 | Synchronous mode, bit clock from `xclk` |
| baud_tick | input | 1 | One-cycle bit strobe in asynchronous mode |
| xclk | input | 1 | External bit clock in synchronous mode |
| ext_wr | input | 1 | Write strobe for the extension register |
| ext_data | input | 8 | Upper data bits 15:8 |
| low_wr | input | 1 | Write strobe for the low byte, starts a character |
| low_data | input | 8 | Data bits 7:0 |
| port_out | input | 1 | Pin value from the ordinary port logic |
| buf_empty | output | 1 | Holding register can accept a character |
| txd | output | 1 | Serial output pin |

## Verification
The checks assume that the configuration inputs stay stable while a frame is in progress or waiting in the holding register. They also assume `baud_tick` pulses last one cycle and `xclk` is slow compared with `clk`, so that each rising edge gives exactly one strobe. The bench changes configuration only when the line is idle and the holding register is empty. It holds `xclk` high and then low for four cycles each, and it issues ticks one at a time with idle cycles between them. Because of this, every bit it samples has settled before the next strobe.

// File: rtl/euart_pkg.sv
package euart_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSV  = 2'b11
    } par_e;

    // Map a requested bit count to a supported one; unsupported counts become 8.
    function automatic logic [4:0] eff_len(input logic [4:0] code);
        case (code)
            5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
            5'd13, 5'd14, 5'd15, 5'd16: eff_len = code;
            default:                    eff_len = 5'd8;
        endcase
    endfunction

endpackage

// File: rtl/euart_bit_strobe.sv
module euart_bit_strobe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic baud_tick,
    input  logic xclk,
    output logic strobe
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;

    always_comb begin
        sync_d[0] = xclk;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        prev_d = sync_q[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // Rising edge of the resynchronised external clock, or the internal tick.
    assign strobe = sync_mode ? (sync_q[TOP] & ~prev_q) : baud_tick;

endmodule

// File: rtl/euart_frame_build.sv
module euart_frame_build
    import euart_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [4:0]         len_code,
    input  logic [1:0]         parity,
    input  logic               stop2,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    logic [4:0] eff;
    logic       par_on;
    logic       pbit;
    par_e       pmode;

    always_comb begin
        pmode  = par_e'(parity);
        eff    = eff_len(len_code);
        par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
        pbit   = (pmode == PAR_ODD);
        frame  = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(eff)) begin
                frame[i+1] = data[i];
                pbit       = pbit ^ data[i];
            end
        end
        for (int k = 1; k < FRAME_W; k++) begin
            if (par_on && (k == int'(eff) + 1)) begin
                frame[k] = pbit;
            end
        end
        nbits = CNT_W'(2 + int'(eff) + (par_on ? 1 : 0) + (stop2 ? 1 : 0));
    end

endmodule

// File: rtl/ext_uart_tx.sv
module ext_uart_tx
    import euart_pkg::*;
#(
    parameter int LOW_W       = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [4:0]         cfg_len,
    input  logic [1:0]         cfg_parity,
    input  logic               cfg_stop2,
    input  logic               cfg_sync,
    input  logic               baud_tick,
    input  logic               xclk,
    input  logic               ext_wr,
    input  logic [DATA_W-LOW_W-1:0] ext_data,
    input  logic               low_wr,
    input  logic [LOW_W-1:0]   low_data,
    input  logic               port_out,
    output logic               buf_empty,
    output logic               txd
);
    localparam int EXT_W   = DATA_W - LOW_W;
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               hold_v;
        logic [EXT_W-1:0]   ext;
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } state_t;

    state_t s_d, s_q;

    logic               strobe_w;
    logic               busy_w;
    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   nbits_w;

    euart_bit_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (cfg_sync),
        .baud_tick (baud_tick),
        .xclk      (xclk),
        .strobe    (strobe_w)
    );

    euart_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .data     (s_q.hold),
        .len_code (cfg_len),
        .parity   (cfg_parity),
        .stop2    (cfg_stop2),
        .frame    (frame_w),
        .nbits    (nbits_w)
    );

    always_comb begin
        s_d = s_q;
        // shift engine
        if (s_q.busy) begin
            if (strobe_w) begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.sh   = '1;
                end else begin
                    s_d.sh  = {1'b1, s_q.sh[FRAME_W-1:1]};
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
        end else if (s_q.hold_v && tx_en) begin
            s_d.busy   = 1'b1;
            s_d.sh     = frame_w;
            s_d.cnt    = nbits_w;
            s_d.hold_v = 1'b0;
        end
        // register writes, accepted only while enabled
        if (tx_en && ext_wr) begin
            s_d.ext = ext_data;
        end
        if (tx_en && low_wr && !s_q.hold_v) begin
            s_d.hold   = {s_q.ext, low_data};
            s_d.hold_v = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{hold: '0, hold_v: 1'b0, ext: '0, busy: 1'b0, sh: '1, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_w    = s_q.busy;
    assign buf_empty = !s_q.hold_v;
    assign txd       = (tx_en || s_q.busy) ? (s_q.busy ? s_q.sh[0] : 1'b1) : port_out;

endmodule

// File: rtl/euart_tx_checker.sv
module euart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic low_wr,
    input logic ext_wr,
    input logic buf_empty,
    input logic txd,
    input logic port_out,
    input logic busy,
    input logic strobe
);
    // R8: idle enabled line is high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !busy) |-> txd);

    // R4: frame begins with a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R7: accepted write fills the holding register
    a_r7_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && low_wr && buf_empty) |=> !buf_empty);

    // R7: holding register empties when the frame loads
    a_r7_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> buf_empty);

    // R3: extension write alone starts nothing
    a_r3_ext_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr && !low_wr && buf_empty && !busy) |=> (!busy && buf_empty));

    // R4: line only moves on a bit strobe during a frame
    a_r4_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !strobe) |=> $stable(txd));

    // R10: disabled pin returns to the port once the frame is over
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !busy) |-> (txd == port_out));
endmodule

bind ext_uart_tx euart_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .low_wr    (low_wr),
    .ext_wr    (ext_wr),
    .buf_empty (buf_empty),
    .txd       (txd),
    .port_out  (port_out),
    .busy      (busy_w),
    .strobe    (strobe_w)
);

// File: tb/test_ext_uart_tx.sv
module test_ext_uart_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [4:0] cfg_len = 5'd8;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_sync = 1'b0;
    logic       baud_tick = 1'b0;
    logic       xclk = 1'b0;
    logic       ext_wr = 1'b0;
    logic [7:0] ext_data = '0;
    logic       low_wr = 1'b0;
    logic [7:0] low_data = '0;
    logic       port_out = 1'b1;
    logic       buf_empty;
    logic       txd;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] cap;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    ext_uart_tx i_ext_uart_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2), .cfg_sync(cfg_sync),
        .baud_tick(baud_tick), .xclk(xclk), .ext_wr(ext_wr), .ext_data(ext_data),
        .low_wr(low_wr), .low_data(low_data), .port_out(port_out),
        .buf_empty(buf_empty), .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [4:0] c);
        if ((c >= 5 && c <= 9) || (c >= 13 && c <= 16)) return int'(c);
        return 8;
    endfunction

    // expected frame from R2/R4/R5/R6/R11, bit 0 first on the line
    function automatic logic [31:0] exp_frame(input logic [4:0] c, input logic [1:0] p,
                                              input logic s2, input logic [15:0] d, output int nb);
        logic [31:0] v;
        int l, pos, ones;
        l = eff(c); v = '1; v[0] = 1'b0; ones = 0;
        for (int i = 0; i < l; i++) begin v[i+1] = d[i]; ones += int'(d[i]); end
        pos = l + 1;
        if (p == 2'b01) begin v[pos] = ones[0]; pos++; end
        else if (p == 2'b10) begin v[pos] = ~ones[0]; pos++; end
        nb = pos + 1 + (s2 ? 1 : 0);
        for (int i = nb; i < 32; i++) v[i] = 1'b0;
        return v;
    endfunction

    task automatic write_ext(input logic [7:0] e);
        @(negedge clk); ext_wr = 1'b1; ext_data = e;
        @(negedge clk); ext_wr = 1'b0;
    endtask

    task automatic write_low(input logic [7:0] b);
        @(negedge clk); low_wr = 1'b1; low_data = b;
        @(negedge clk); low_wr = 1'b0;
    endtask

    // sample cnt bits starting at index from, one strobe after each sample
    task automatic cap_bits(input int from, input int cnt, input bit sync);
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            cap[from+k] = txd;
            if (sync) begin
                xclk = 1'b1;
                repeat (2) @(negedge clk);
                baud_tick = 1'b1;          // R9: must be ignored
                @(negedge clk); baud_tick = 1'b0;
                @(negedge clk); xclk = 1'b0;
                repeat (4) @(negedge clk);
            end else begin
                baud_tick = 1'b1;
                @(negedge clk); baud_tick = 1'b0;
            end
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic frame_test(input logic [4:0] c, input logic [1:0] p, input logic s2,
                              input bit sync, input string req);
        logic [31:0] r, e;
        int nb;
        r = rnd();
        cfg_len = c; cfg_parity = p; cfg_stop2 = s2; cfg_sync = sync;
        write_ext(r[23:16]);
        write_low(r[15:8]);
        e = exp_frame(c, p, s2, {r[23:16], r[15:8]}, nb);
        cap = '0;
        repeat (2) @(negedge clk);
        cap_bits(0, nb, sync);
        chk(cap == e, req, cap, e);
        @(negedge clk);
        chk(txd == 1'b1 && buf_empty, "R8 idle after frame", {30'd0, buf_empty, txd}, 32'd3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] e;
        int nb;
        int lens[9] = '{5, 6, 7, 8, 9, 13, 14, 15, 16};
        port_out = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(buf_empty == 1'b1, "R1 reset empty", 32'(buf_empty), 32'd1);
        chk(txd == 1'b0, "R1 pin follows port", 32'(txd), 32'd0);
        port_out = 1'b1; @(negedge clk);
        chk(txd == 1'b1, "R1 pin follows port high", 32'(txd), 32'd1);

        // R10: writes while disabled are ignored
        port_out = 1'b0;
        write_low(8'h5A);
        repeat (3) @(negedge clk);
        chk(buf_empty == 1'b1 && txd == 1'b0, "R10 write while disabled", {30'd0, buf_empty, txd}, 32'd2);

        tx_en = 1'b1; @(negedge clk);
        chk(txd == 1'b1, "R8 idle high when enabled", 32'(txd), 32'd1);

        // R3: extension write alone starts nothing
        write_ext(8'hA5);
        repeat (4) @(negedge clk);
        chk(buf_empty && txd, "R3 ext write no start", {30'd0, buf_empty, txd}, 32'd3);

        // R7 timing around the launch
        cfg_len = 5'd16; cfg_parity = 2'b00; cfg_stop2 = 1'b0;
        @(negedge clk); low_wr = 1'b1; low_data = 8'h3C;
        @(negedge clk); low_wr = 1'b0;
        chk(buf_empty == 1'b0, "R7 empty clears after write", 32'(buf_empty), 32'd0);
        @(negedge clk);
        chk(buf_empty == 1'b1 && txd == 1'b0, "R7 empty sets at load with start bit", {30'd0, buf_empty, txd}, 32'd2);
        e = exp_frame(5'd16, 2'b00, 1'b0, 16'hA53C, nb);
        cap = '0;
        cap_bits(0, nb, 1'b0);
        chk(cap == e, "R3 ext+low data in 16-bit frame", cap, e);

        // sweep: lengths x parity x stop bits, asynchronous
        foreach (lens[li]) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 2; s++) begin
                    frame_test(5'(lens[li]), 2'(p), 1'(s), 1'b0,
                               lens[li] <= 8 ? "R4 R5 R6 R11 frame" : "R4 R5 R6 R3 frame");
                end
            end
        end
        // R2: unsupported codes behave as 8
        frame_test(5'd0, 2'b01, 1'b0, 1'b0, "R2 code 0 as 8");
        frame_test(5'd10, 2'b10, 1'b1, 1'b0, "R2 code 10 as 8");
        frame_test(5'd31, 2'b00, 1'b0, 1'b0, "R2 code 31 as 8");
        // R9: synchronous mode
        frame_test(5'd9, 2'b01, 1'b1, 1'b1, "R9 sync frame 9");
        frame_test(5'd14, 2'b10, 1'b0, 1'b1, "R9 sync frame 14");
        frame_test(5'd5, 2'b00, 1'b0, 1'b1, "R9 sync frame 5");

        // R7: back-to-back, write while full ignored
        cfg_sync = 1'b0; cfg_len = 5'd8; cfg_parity = 2'b00; cfg_stop2 = 1'b0;
        write_low(8'h81);
        repeat (2) @(negedge clk);
        cap = '0;
        cap_bits(0, 3, 1'b0);
        write_low(8'h6E);
        chk(buf_empty == 1'b0, "R7 second char held", 32'(buf_empty), 32'd0);
        write_low(8'hFF);
        cap_bits(3, 7, 1'b0);
        e = exp_frame(5'd8, 2'b00, 1'b0, 16'h0081, nb);
        chk(cap == e, "R7 first frame", cap, e);
        repeat (3) @(negedge clk);
        cap = '0;
        cap_bits(0, 10, 1'b0);
        e = exp_frame(5'd8, 2'b00, 1'b0, 16'h006E, nb);
        chk(cap == e, "R7 held char sent, full write ignored", cap, e);
        @(negedge clk);
        chk(buf_empty == 1'b1, "R7 empty after both", 32'(buf_empty), 32'd1);

        // R10: disable during a frame
        port_out = 1'b0; cfg_parity = 2'b01; cfg_stop2 = 1'b1;
        write_low(8'hC3);
        repeat (2) @(negedge clk);
        cap = '0;
        cap_bits(0, 3, 1'b0);
        tx_en = 1'b0;
        e = exp_frame(5'd8, 2'b01, 1'b1, 16'h00C3, nb);
        cap_bits(3, nb - 3, 1'b0);
        chk(cap == e, "R10 frame completes after disable", cap, e);
        @(negedge clk);
        chk(txd == 1'b0, "R10 pin back to port", 32'(txd), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule